// File: doc/BRIEF.md
# Hash Message Input Buffer

This block collects 32-bit message words for a block hash engine and hands them over a full 512-bit block at a time. Words arrive on a write port with a valid/ready handshake. Once sixteen words are held and the engine is idle, the block presents the whole block to the engine. On the next edge it marks the engine busy and empties its storage, so the next block can be written while the engine works. When the buffer is full again and the engine is still busy, further writes are stalled, never dropped.

Alongside the storage, the block keeps the status seen by software: a fill count, a not-empty bit, a busy bit, and two sticky event flags. One flag means "a whole block is free". The other means "digest complete". Software clears a sticky flag by writing zero to its bit. Each event flag drives an interrupt line gated by a mask bit. A DMA path requests words while an enable bit is set. That enable bit turns itself off when the transfer's last word is accepted. A soft init empties the buffer and clears all status. The engine is modelled only by a done pulse that ends a block and a separate digest-complete pulse.

Top module: `hash_infifo`

## Requirements
- R1: After reset the fill count is 0, all status flags, DMA enable and both interrupt lines are 0, `wr_ready` is 1 and `blk_valid` is 0.
- R2: A write accepted on a rising edge (`wr_valid` and `wr_ready`) is stored in the next free slot, and the fill count rises by one after that edge. The count appears on `ctrl_word` bits [12:8]. `stat_nempty` is 1 exactly when the count is non-zero.
- R3: `wr_ready` is 0 exactly while sixteen words are held. While it is 0, no word is stored and the count does not change.
- R4: `blk_valid` is 1 whenever sixteen words are held and the engine is not busy. `blk_data` bits [32k+31:32k] hold the k-th accepted word, with k=0 first. After that edge, busy is 1, the count is 0 and the block-free flag (`stat_din`) is set.
- R5: While busy, a `core_done` pulse clears busy on the next edge. Without it, busy stays set. `core_done` has no effect while not busy.
- R6: A status write (`sts_wr`) clears the block-free flag when `sts_wdata[0]` is 0 and the digest flag when `sts_wdata[1]` is 0. A 1 bit leaves its flag unchanged. A set event in the same cycle wins over the clear.
- R7: A `core_dgst` pulse sets the digest-complete flag (`stat_dgst`) on the next edge.
- R8: `irq_din` equals `stat_din` AND `int_mask[0]`. `irq_dgst` equals `stat_dgst` AND `int_mask[1]`.
- R9: `soft_init` overrides every other input. After the edge, the count is 0, and busy, both flags, DMA enable and DMA status are 0.
- R10: A `dma_on` pulse sets DMA enable, which is shown on `ctrl_word` bit 3. `dma_req` equals DMA enable AND `wr_ready`. An accepted write with `wr_last` set while DMA is enabled clears the enable on the next edge, unless `dma_on` is also high in that cycle.
- R11: `stat_dmas` is 1 while DMA is enabled, or from the acceptance of the last DMA word until the next block handover or init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_init | input | 1 | Empties the buffer and clears all status |
| wr_valid | input | 1 | Message word offered |
| wr_data | input | 32 | Message word |
| wr_last | input | 1 | Word is the final word of a DMA transfer |
| wr_ready | output | 1 | Buffer can accept a word |
| blk_valid | output | 1 | Full block offered to the engine |
| blk_data | output | 512 | Sixteen words, first word in the low bits |
| core_done | input | 1 | Engine finished the current block |
| core_dgst | input | 1 | Engine finished a digest |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Bit 0 block-free flag, bit 1 digest flag; 0 clears |
| int_mask | input | 2 | Bit 0 enables irq_din, bit 1 enables irq_dgst |
| dma_on | input | 1 | Enables DMA requests |
| dma_req | output | 1 | DMA word request |
| irq_din | output | 1 | Block-free interrupt |
| irq_dgst | output | 1 | Digest-complete interrupt |
| stat_din | output | 1 | Block-free flag |
| stat_dgst | output | 1 | Digest-complete flag |
| stat_nempty | output | 1 | At least one word held |
| stat_busy | output | 1 | Engine processing a block |
| stat_dmas | output | 1 | DMA enabled or its data still pending |
| ctrl_word | output | 32 | Fill count at [12:8], DMA enable at bit 3 |

## Verification
The sharpest collision is the block handover, which sets the block-free flag, landing in the same cycle as a software write that clears that flag. The same collision arises between a digest pulse and a clear of the digest flag. The directed phase fills sixteen words and issues a clearing status write exactly in the handover cycle. The random phase mixes frequent status writes with digest pulses so that both collisions recur. In each case the flag must read 1 after the edge, and the bench model applies set-over-clear priority to judge it. A second overlap, the last DMA word accepted while `dma_on` pulses, is judged by the DMA enable staying set.

// File: rtl/hinf_pkg.sv
package hinf_pkg;

  // next fill level: a drain empties the buffer, otherwise a push adds one
  function automatic int unsigned fill_next(input int unsigned cur,
                                            input logic push,
                                            input logic drain);
    if (drain) return 0;
    return cur + (push ? 1 : 0);
  endfunction

  // sticky flag: hardware set beats a write-zero clear; a written 1 keeps it
  function automatic logic flag_next(input logic cur, input logic set,
                                     input logic wr, input logic wbit);
    if (set) return 1'b1;
    if (wr && !wbit) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/hinf_store.sv
module hinf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CW-1:0]       widx,
  input  logic [DW-1:0]       wdata,
  output logic [DEPTH*DW-1:0] flat
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          word_q <= '0;
      else if (we && (widx == CW'(i)))     word_q <= wdata;
    end
    assign flat[i*DW +: DW] = word_q;
  end
endmodule

// File: rtl/hinf_ctl.sv
module hinf_ctl
  import hinf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          push,
  input  logic          core_done,
  output logic          full,
  output logic          handover,
  output logic          busy,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  assign full     = (cnt == FULL_CNT);
  assign handover = full && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (init) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else begin
      cnt <= CW'(fill_next(int'(cnt), push, handover));
      if (handover)       busy <= 1'b1;
      else if (core_done) busy <= 1'b0;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  // R4
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (handover && !init) |=> (busy && cnt == '0));
  // R3
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && busy && !core_done && !init) |=> (cnt == FULL_CNT));
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_done && !init) |=> busy);
endmodule

// File: rtl/hinf_flags.sv
module hinf_flags
  import hinf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       din_set,
  input  logic       dgst_set,
  input  logic       sts_wr,
  input  logic [1:0] sts_wdata,
  input  logic [1:0] int_mask,
  output logic       din_flag,
  output logic       dgst_flag,
  output logic       irq_din,
  output logic       irq_dgst
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_flag  <= 1'b0;
      dgst_flag <= 1'b0;
    end else if (init) begin
      din_flag  <= 1'b0;
      dgst_flag <= 1'b0;
    end else begin
      din_flag  <= flag_next(din_flag,  din_set,  sts_wr, sts_wdata[0]);
      dgst_flag <= flag_next(dgst_flag, dgst_set, sts_wr, sts_wdata[1]);
    end
  end

  assign irq_din  = din_flag  & int_mask[0];
  assign irq_dgst = dgst_flag & int_mask[1];

  // R6
  din_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !sts_wdata[0] && !din_set) |=> !din_flag);
  // R6
  din_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_set && !init) |=> din_flag);
  // R7
  dgst_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dgst_set && !init) |=> dgst_flag);
endmodule

// File: rtl/hinf_dma.sv
module hinf_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic dma_on,
  input  logic push,
  input  logic wr_last,
  input  logic handover,
  input  logic wr_ready,
  output logic dma_en,
  output logic dma_req,
  output logic dmas
);
  logic last_acc;
  logic tail;

  assign last_acc = push && wr_last && dma_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en <= 1'b0;
      tail   <= 1'b0;
    end else if (init) begin
      dma_en <= 1'b0;
      tail   <= 1'b0;
    end else begin
      if (dma_on)        dma_en <= 1'b1;
      else if (last_acc) dma_en <= 1'b0;
      if (last_acc)      tail   <= 1'b1;
      else if (handover) tail   <= 1'b0;
    end
  end

  assign dma_req = dma_en & wr_ready;
  assign dmas    = dma_en | tail;

  // R10
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && !dma_on && !init) |=> !dma_en);
  // R11
  dma_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_acc && !init) |=> dmas);
endmodule

// File: rtl/hash_infifo.sv
module hash_infifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_init,
  input  logic                wr_valid,
  input  logic [DW-1:0]       wr_data,
  input  logic                wr_last,
  output logic                wr_ready,
  output logic                blk_valid,
  output logic [DEPTH*DW-1:0] blk_data,
  input  logic                core_done,
  input  logic                core_dgst,
  input  logic                sts_wr,
  input  logic [1:0]          sts_wdata,
  input  logic [1:0]          int_mask,
  input  logic                dma_on,
  output logic                dma_req,
  output logic                irq_din,
  output logic                irq_dgst,
  output logic                stat_din,
  output logic                stat_dgst,
  output logic                stat_nempty,
  output logic                stat_busy,
  output logic                stat_dmas,
  output logic [31:0]         ctrl_word
);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int CNT_LSB  = 8;
  localparam int DMAE_BIT = 3;

  logic          full;
  logic          push;
  logic          handover;
  logic          busy;
  logic          dma_en;
  logic [CW-1:0] fill;

  assign wr_ready = !full;
  assign push     = wr_valid && wr_ready;

  hinf_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push), .widx(fill),
    .wdata(wr_data), .flat(blk_data)
  );

  hinf_ctl #(.DEPTH(DEPTH), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .init(soft_init), .push(push),
    .core_done(core_done), .full(full), .handover(handover),
    .busy(busy), .cnt(fill)
  );

  hinf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .init(soft_init), .din_set(handover),
    .dgst_set(core_dgst), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .int_mask(int_mask), .din_flag(stat_din), .dgst_flag(stat_dgst),
    .irq_din(irq_din), .irq_dgst(irq_dgst)
  );

  hinf_dma u_dma (
    .clk(clk), .rst_n(rst_n), .init(soft_init), .dma_on(dma_on),
    .push(push), .wr_last(wr_last), .handover(handover),
    .wr_ready(wr_ready), .dma_en(dma_en), .dma_req(dma_req),
    .dmas(stat_dmas)
  );

  assign blk_valid   = handover;
  assign stat_busy   = busy;
  assign stat_nempty = (fill != '0);

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[CNT_LSB +: CW]   = fill;
    ctrl_word[DMAE_BIT]        = dma_en;
  end

  // R9
  init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_init |=> (fill == '0 && !busy && !stat_din && !stat_dgst && !stat_dmas));
  // R3
  no_store_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !handover && !soft_init) |=> $stable(fill));
endmodule

// File: tb/test_hash_infifo.sv
module test_hash_infifo;
  localparam int W = 32;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           soft_init, wr_valid, wr_last, core_done, core_dgst, sts_wr, dma_on;
  logic [W-1:0]   wr_data;
  logic [1:0]     sts_wdata, int_mask;
  logic           wr_ready, blk_valid, dma_req, irq_din, irq_dgst;
  logic           stat_din, stat_dgst, stat_nempty, stat_busy, stat_dmas;
  logic [N*W-1:0] blk_data;
  logic [31:0]    ctrl_word;

  hash_infifo i_hash_infifo (
    .clk(clk), .rst_n(rst_n), .soft_init(soft_init), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .blk_valid(blk_valid), .blk_data(blk_data), .core_done(core_done),
    .core_dgst(core_dgst), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .int_mask(int_mask), .dma_on(dma_on), .dma_req(dma_req),
    .irq_din(irq_din), .irq_dgst(irq_dgst), .stat_din(stat_din),
    .stat_dgst(stat_dgst), .stat_nempty(stat_nempty), .stat_busy(stat_busy),
    .stat_dmas(stat_dmas), .ctrl_word(ctrl_word)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state kept by the bench
  int         m_cnt;
  bit         m_busy, m_din, m_dgst, m_dma, m_tail;
  logic [W-1:0] m_words [N];

  task automatic check(input bit ok, input string tag,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] exp_block();
    logic [N*W-1:0] b;
    for (int k = 0; k < N; k++) b[k*W +: W] = m_words[k];
    return b;
  endfunction

  function automatic bit e_ready();
    return m_cnt < N;
  endfunction

  function automatic bit e_blk();
    return (m_cnt == N) && !m_busy;
  endfunction

  task automatic compare_all();
    check(ctrl_word[12:8] == 5'(m_cnt), "R2 fill count", ctrl_word[12:8], m_cnt);
    check(stat_nempty == (m_cnt != 0), "R2 not-empty", stat_nempty, m_cnt != 0);
    check(wr_ready == e_ready(), "R3 ready", wr_ready, e_ready());
    check(blk_valid == e_blk(), "R4 blk_valid", blk_valid, e_blk());
    if (e_blk()) check(blk_data == exp_block(), "R4 blk_data", blk_data, exp_block());
    check(stat_busy == m_busy, "R5 busy", stat_busy, m_busy);
    check(stat_din == m_din, "R6 din flag", stat_din, m_din);
    check(stat_dgst == m_dgst, "R7 dgst flag", stat_dgst, m_dgst);
    check({irq_dgst, irq_din} == ({m_dgst, m_din} & int_mask), "R8 irq",
          {irq_dgst, irq_din}, {m_dgst, m_din} & int_mask);
    check(ctrl_word[3] == m_dma, "R10 dma enable", ctrl_word[3], m_dma);
    check(dma_req == (m_dma && e_ready()), "R10 dma_req", dma_req, m_dma && e_ready());
    check(stat_dmas == (m_dma || m_tail), "R11 dmas", stat_dmas, m_dma || m_tail);
  endtask

  // advance the reference across one rising edge using the held inputs
  task automatic model_edge();
    bit acc, hand, lastd;
    if (soft_init) begin
      m_cnt = 0; m_busy = 0; m_din = 0; m_dgst = 0; m_dma = 0; m_tail = 0;
      return;
    end
    acc   = wr_valid && e_ready();
    hand  = e_blk();
    lastd = acc && wr_last && m_dma;
    if (acc) begin
      m_words[m_cnt] = wr_data;
      m_cnt++;
    end
    if (hand) m_cnt = 0;
    if (hand) m_busy = 1;
    else if (m_busy && core_done) m_busy = 0;
    if (hand) m_din = 1;
    else if (sts_wr && sts_wdata[0] == 1'b0) m_din = 0;
    if (core_dgst) m_dgst = 1;
    else if (sts_wr && sts_wdata[1] == 1'b0) m_dgst = 0;
    if (lastd) m_tail = 1;
    else if (hand) m_tail = 0;
    if (dma_on) m_dma = 1;
    else if (lastd) m_dma = 0;
  endtask

  // called at a falling edge: drive, check, cross the rising edge, return at falling edge
  task automatic step(input bit i_init, input bit wv, input logic [W-1:0] wd,
                      input bit wl, input bit cd, input bit cg, input bit sw,
                      input logic [1:0] swd, input logic [1:0] msk, input bit don);
    soft_init = i_init; wr_valid = wv; wr_data = wd; wr_last = wl;
    core_done = cd; core_dgst = cg; sts_wr = sw; sts_wdata = swd;
    int_mask = msk; dma_on = don;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    {soft_init, wr_valid, wr_last, core_done, core_dgst, sts_wr, dma_on} = '0;
    wr_data = '0; sts_wdata = 2'b11; int_mask = 2'b11;
    m_cnt = 0; m_busy = 0; m_din = 0; m_dgst = 0; m_dma = 0; m_tail = 0;
    for (int k = 0; k < N; k++) m_words[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(ctrl_word == 32'd0 && !stat_din && !stat_dgst && !stat_busy && !stat_nempty
          && !stat_dmas, "R1 status after reset", ctrl_word, 0);
    check(wr_ready && !blk_valid && !irq_din && !irq_dgst && !dma_req,
          "R1 handshake after reset", {wr_ready, blk_valid, irq_din, irq_dgst}, 4'b1000);

    // R2/R4: fill one block in order, then clear din in the handover cycle (R6 set wins)
    for (int k = 0; k < N; k++)
      step(0, 1, 32'hA000_0000 + 32'(k), 0, 0, 0, 0, 2'b11, 2'b01, 0);
    step(0, 1, 32'hDEAD_BEEF, 0, 0, 0, 1, 2'b10, 2'b01, 0);
    // R3: refill while busy, then push against a full buffer
    for (int k = 0; k < N + 4; k++)
      step(0, 1, 32'hB000_0000 + 32'(k), 0, 0, 0, 0, 2'b11, 2'b11, 0);
    // R5: release the engine, next block goes over; digest pulse and clear together (R7)
    step(0, 0, '0, 0, 1, 1, 1, 2'b00, 2'b11, 0);
    step(0, 0, '0, 0, 0, 0, 0, 2'b11, 2'b11, 0);
    step(0, 0, '0, 0, 0, 0, 1, 2'b01, 2'b11, 0);
    step(0, 0, '0, 0, 1, 0, 0, 2'b11, 2'b11, 0);
    // R10/R11: DMA transfer of three words, last one switches DMA off
    step(0, 0, '0, 0, 0, 0, 0, 2'b11, 2'b11, 1);
    step(0, 1, 32'hC1, 0, 0, 0, 0, 2'b11, 2'b11, 0);
    step(0, 1, 32'hC2, 0, 0, 0, 0, 2'b11, 2'b11, 0);
    step(0, 1, 32'hC3, 1, 0, 0, 0, 2'b11, 2'b11, 0);
    step(0, 0, '0, 0, 0, 0, 0, 2'b11, 2'b11, 0);
    // R10: last word and dma_on together keep DMA enabled
    step(0, 1, 32'hC4, 1, 0, 0, 0, 2'b11, 2'b11, 1);
    step(0, 1, 32'hC5, 1, 0, 0, 0, 2'b11, 2'b11, 1);
    // R9: init with a write offered
    step(1, 1, 32'hFF, 0, 0, 1, 0, 2'b11, 2'b11, 1);
    #1;
    check(ctrl_word == 32'd0 && !stat_din && !stat_dgst && !stat_busy && !stat_dmas,
          "R9 init clears", ctrl_word, 0);
    @(negedge clk);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      bit r_init, r_wv, r_wl, r_cd, r_cg, r_sw, r_don;
      r_init = ($urandom_range(0, 299) == 0);
      r_wv   = ($urandom_range(0, 3) != 0);
      r_wl   = ($urandom_range(0, 19) == 0);
      r_cd   = ($urandom_range(0, 5) == 0);
      r_cg   = ($urandom_range(0, 15) == 0);
      r_sw   = ($urandom_range(0, 5) == 0);
      r_don  = ($urandom_range(0, 29) == 0);
      step(r_init, r_wv, $urandom(), r_wl, r_cd, r_cg, r_sw,
           2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), r_don);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule